// File: doc/BRIEF.md
# Masked Vector Tree Reduction Engine

This block folds a vector of up to `LANES` signed or unsigned integers into a single scalar by two's-complement wrapping addition. Each element comes with its own enable bit. A start pulse captures the element array, the enable bits and an active length. The engine then runs one combining pass per clock. Each pass pairs lanes at a stride that doubles every time, so the number of passes grows with the logarithm of the active length.

The pairing order is a fixed binary tree, so the result does not depend on how the adder would behave if its operands were reordered. An enabled lane whose partner is disabled keeps its own value. A disabled lane whose partner is enabled adopts the partner's value. The enable bits of the lanes that act are ORed with their partner's status. When the passes end, the engine pulses `done`. It presents lane 0 as the result, with a validity flag, and the final enable vector as a condition output. All three stay held until the next reduction completes.

Top module: `vred_engine`

## Requirements
- R1: After reset, `busy`, `done`, `result_valid`, `result` and `cond_out` are all zero.
- R2: When a start is accepted, working enable bit i is set to `mask_in[i]` for i below `vlen`, and to 0 for i at or above `vlen`. Only lanes whose working bit is set take their element, at `elem_in[i*DW +: DW]`; the other lanes are loaded with 0.
- R3: If start is sampled at clock edge k, `busy` is high from edge k until edge k+1+P, and `done` is high for exactly the one cycle after edge k+1+P. P is the number of passes: 0 for `vlen` of 0 or 1, otherwise ceil(log2(`vlen`)).
- R4: Pass n (n = 1, 2, ...) uses a doubled stride D = 2^n. Only lanes i with i mod D = 0 act, and each pairs with partner i + D/2. A partner is active only if its index is below `vlen` and its working bit is set.
- R5: An acting lane that is active with an active partner becomes the sum, modulo 2^DW, of its own value and the partner's value.
- R6: An acting lane whose own bit is clear and whose partner is active takes the partner's value unchanged. A lane whose partner is inactive keeps its value.
- R7: After each pass, the working bit of an acting lane is its old bit ORed with the partner's active flag. `cond_out` shows the final working enable vector from `done` onward, and bits at or above `vlen` are 0.
- R8: `result_valid` is 1 only if `vlen` is nonzero and final working bit 0 is set. In that case `result` is lane 0. Otherwise `result_valid` is 0 and `result` is 0.
- R9: A start that arrives while `busy` is high is ignored. It produces no `done` and does not change the reduction in progress.
- R10: `result`, `result_valid` and `cond_out` hold their values until the next reduction completes. `vlen` must not exceed `LANES`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a reduction (accepted only when idle) |
| vlen | input | $clog2(LANES+1) | Active vector length, 0 to LANES |
| elem_in | input | LANES*DW | Element array, lane i at bits i*DW +: DW |
| mask_in | input | LANES | Per-element enable bits |
| busy | output | 1 | A reduction is in progress |
| done | output | 1 | One-cycle pulse when the result is ready |
| result_valid | output | 1 | The result holds a reduced value |
| result | output | DW | Reduced scalar (lane 0), 0 when not valid |
| cond_out | output | LANES | Final working enable vector |

## Verification
The bench covers several boundary cases. A zero length must give no valid result even if every mask bit is set; a design that ignored the length check would report a stale lane 0. When only the last lane is enabled, its value must travel down to lane 0; a design that skipped adopting the partner's value would return 0 with the valid flag clear. Mask bits above the length must stay out of both the sum and `cond_out`, and all-ones operands must wrap. A second start pulsed while the engine is busy must produce no extra `done` and must not disturb the result; an engine that restarted would shift the `done` cycle and change the sum.

// File: rtl/vred_pkg.sv
// Package: shared types for the masked vector tree reduction engine.
// Assumes nothing beyond IEEE 1800-2017 enum support.
package vred_pkg;
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } vred_state_e;
endpackage

// File: rtl/vred_ctrl.sv
// Module: sequencer for the reduction engine.
// Accepts start only when idle, then issues one pass strobe per cycle while
// the current stride is below the captured length, then one finish strobe.
// Assumes vlen_q is stable during a run (it is loaded together with start).
module vred_ctrl
    import vred_pkg::*;
#(
    parameter int LANES = 8,
    parameter int LW    = $clog2(LANES + 1),
    parameter int SW    = $clog2(LANES) + 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [LW-1:0] vlen_q,
    output logic          busy,
    output logic          load,
    output logic          pass_en,
    output logic          fin,
    output logic [SW-1:0] stride
);
    localparam int PMAX = $clog2(LANES);

    vred_state_e state_q;
    logic [SW-1:0] stride_q;
    logic          more;
    logic [SW-1:0] pass_cnt;

    // Decode the current state into strobes.
    always_comb begin
        more    = stride_q < SW'(vlen_q);
        busy    = (state_q == ST_RUN);
        load    = (state_q == ST_IDLE) && start;
        pass_en = busy && more;
        fin     = busy && !more;
        stride  = stride_q;
    end

    // State and stride register: stride restarts at 1 and doubles per pass.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            stride_q <= SW'(1);
        end else if (load) begin
            state_q  <= ST_RUN;
            stride_q <= SW'(1);
        end else if (pass_en) begin
            stride_q <= stride_q << 1;
        end else if (fin) begin
            state_q  <= ST_IDLE;
        end
    end

    // Pass counter kept for the pass-count bound check below.
    always_ff @(posedge clk) begin
        if (!rst_n || load) pass_cnt <= '0;
        else if (pass_en)   pass_cnt <= pass_cnt + SW'(1);
    end

    p_pass_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (pass_cnt <= SW'(PMAX)));

    p_stride_pow2_r4: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> ($onehot0(stride_q) && stride_q != '0));

    p_fin_leaves_r3: assert property (@(posedge clk) disable iff (!rst_n)
        fin |=> !busy);
endmodule

// File: rtl/vred_pass.sv
// Module: combinational single pass of the tree reduction.
// For half-stride H, lanes that are multiples of 2H combine with lane i+H.
// Assumes half is a power of two; partner lanes never act in the same pass,
// so every lane reads only current-pass values.
module vred_pass #(
    parameter int LANES = 8,
    parameter int DW    = 16,
    parameter int LW    = $clog2(LANES + 1),
    parameter int SW    = $clog2(LANES) + 2
) (
    input  logic [LW-1:0]             vlen_q,
    input  logic [SW-1:0]             half,
    input  logic [LANES-1:0][DW-1:0]  cur_val,
    input  logic [LANES-1:0]          cur_msk,
    output logic [LANES-1:0][DW-1:0]  nxt_val,
    output logic [LANES-1:0]          nxt_msk
);
    for (genvar gi = 0; gi < LANES; gi++) begin : g_lane
        logic          acts;
        logic          p_act;
        logic [DW-1:0] p_val;

        // Find this lane's partner and whether it is active.
        always_comb begin
            acts  = ((gi & ((int'(half) << 1) - 1)) == 0);
            p_act = 1'b0;
            p_val = '0;
            for (int j = 0; j < LANES; j++) begin
                if (j == gi + int'(half) && j < int'(vlen_q)) begin
                    p_act = cur_msk[j];
                    p_val = cur_val[j];
                end
            end
        end

        // Predicated combine: sum, adopt, or keep.
        always_comb begin
            nxt_val[gi] = cur_val[gi];
            nxt_msk[gi] = cur_msk[gi];
            if (acts) begin
                if (cur_msk[gi] && p_act) nxt_val[gi] = cur_val[gi] + p_val;
                else if (p_act)           nxt_val[gi] = p_val;
                nxt_msk[gi] = cur_msk[gi] | p_act;
            end
        end
    end
endmodule

// File: rtl/vred_engine.sv
// Module: top of the masked vector tree reduction engine.
// Holds the working lane file and working mask, loads them on an accepted
// start, applies one pass per cycle and latches the result on finish.
// Assumes vlen <= LANES when start is accepted.
module vred_engine #(
    parameter int LANES = 8,
    parameter int DW    = 16,
    parameter int LW    = $clog2(LANES + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic [LW-1:0]        vlen,
    input  logic [LANES*DW-1:0]  elem_in,
    input  logic [LANES-1:0]     mask_in,
    output logic                 busy,
    output logic                 done,
    output logic                 result_valid,
    output logic [DW-1:0]        result,
    output logic [LANES-1:0]     cond_out
);
    localparam int SW = $clog2(LANES) + 2;

    logic                      load, pass_en, fin;
    logic [SW-1:0]             stride;
    logic [LW-1:0]             vlen_q;
    logic [LANES-1:0][DW-1:0]  val_q, val_nxt;
    logic [LANES-1:0]          msk_q, msk_nxt;
    logic [LANES-1:0]          below_len;

    vred_ctrl #(.LANES(LANES), .LW(LW), .SW(SW)) ctrl_i (
        .clk(clk), .rst_n(rst_n), .start(start), .vlen_q(vlen_q),
        .busy(busy), .load(load), .pass_en(pass_en), .fin(fin),
        .stride(stride)
    );

    vred_pass #(.LANES(LANES), .DW(DW), .LW(LW), .SW(SW)) pass_i (
        .vlen_q(vlen_q), .half(stride), .cur_val(val_q), .cur_msk(msk_q),
        .nxt_val(val_nxt), .nxt_msk(msk_nxt)
    );

    // Lanes inside the captured length, for the range check.
    always_comb begin
        for (int i = 0; i < LANES; i++) below_len[i] = (i < int'(vlen_q));
    end

    // Working lane file and mask: parallel load, then per-pass update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            val_q  <= '0;
            msk_q  <= '0;
            vlen_q <= '0;
        end else if (load) begin
            vlen_q <= vlen;
            for (int i = 0; i < LANES; i++) begin
                if (i < int'(vlen) && mask_in[i]) begin
                    msk_q[i] <= 1'b1;
                    val_q[i] <= elem_in[i*DW +: DW];
                end else begin
                    msk_q[i] <= 1'b0;
                    val_q[i] <= '0;
                end
            end
        end else if (pass_en) begin
            val_q <= val_nxt;
            msk_q <= msk_nxt;
        end
    end

    // Result latch and done pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done         <= 1'b0;
            result_valid <= 1'b0;
            result       <= '0;
            cond_out     <= '0;
        end else begin
            done <= fin;
            if (fin) begin
                result_valid <= (vlen_q != '0) && msk_q[0];
                result       <= ((vlen_q != '0) && msk_q[0]) ? val_q[0] : '0;
                cond_out     <= msk_q;
            end
        end
    end

    p_done_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_mask_grows_r7: assert property (@(posedge clk) disable iff (!rst_n)
        pass_en |=> ((msk_q & $past(msk_q)) == $past(msk_q)));

    p_cond_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ((cond_out & ~below_len) == '0));

    p_valid_cond_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (done && result_valid) |-> (cond_out[0] && vlen_q != '0));

    p_busy_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> $stable(vlen_q));
endmodule

// File: tb/vred_engine_tb.sv
`timescale 1ns/100ps
module vred_engine_tb_top;
    localparam int LANES = 8;
    localparam int DW    = 16;
    localparam int LW    = $clog2(LANES + 1);

    typedef struct {
        logic [DW-1:0]    res;
        logic             vld;
        logic [LANES-1:0] cond;
        int               cyc;
        string            tag;
    } exp_t;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic                start = 1'b0;
    logic [LW-1:0]       vlen = '0;
    logic [LANES*DW-1:0] elem_in = '0;
    logic [LANES-1:0]    mask_in = '0;
    logic                busy, done, result_valid;
    logic [DW-1:0]       result;
    logic [LANES-1:0]    cond_out;

    int   checks = 0;
    int   fails  = 0;
    int   cyc    = 0;
    exp_t sb[$];

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    vred_engine #(.LANES(LANES), .DW(DW), .LW(LW)) dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .vlen(vlen),
        .elem_in(elem_in), .mask_in(mask_in), .busy(busy), .done(done),
        .result_valid(result_valid), .result(result), .cond_out(cond_out)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // Reference model taken from the requirements: returns the expected item.
    function automatic exp_t model(input int vl, input logic [LANES-1:0] m_in,
                                   input logic [LANES*DW-1:0] e_in, input string tag);
        logic [DW-1:0] v [LANES];
        logic          m [LANES];
        int            step, passes, other;
        logic          op;
        exp_t          e;
        for (int i = 0; i < LANES; i++) begin
            m[i] = (i < vl) && m_in[i];
            v[i] = m[i] ? e_in[i*DW +: DW] : '0;
        end
        step = 1; passes = 0;
        while (step < vl) begin
            step *= 2; passes++;
            for (int i = 0; i < LANES; i += step) begin
                other = i + step / 2;
                op = (other < vl) && m[other];
                if (m[i] && op) v[i] = v[i] + v[other];
                else if (op)    v[i] = v[other];
                m[i] = m[i] | op;
            end
        end
        e.vld = (vl != 0) && m[0];
        e.res = e.vld ? v[0] : '0;
        for (int i = 0; i < LANES; i++) e.cond[i] = m[i];
        e.cyc = cyc + 2 + passes;
        e.tag = tag;
        return e;
    endfunction

    // Driver: computes the expectation, queues it, pulses start at negedge.
    task automatic run(input int vl, input logic [LANES-1:0] m,
                       input logic [LANES*DW-1:0] e, input string tag);
        @(negedge clk);
        vlen = LW'(vl); mask_in = m; elem_in = e; start = 1'b1;
        sb.push_back(model(vl, m, e, tag));
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic drain();
        while (sb.size() != 0) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    // Monitor: pops an expectation for every done pulse and compares.
    always @(negedge clk) begin
        if (rst_n && done) begin
            if (sb.size() == 0) begin
                chk("R9 unexpected done", 32'(done), 32'(0));
            end else begin
                exp_t e;
                e = sb.pop_front();
                chk({e.tag, " R3 done cycle"}, 32'(cyc), 32'(e.cyc));
                chk({e.tag, " R8 valid"}, 32'(result_valid), 32'(e.vld));
                chk({e.tag, " R5 result"}, 32'(result), 32'(e.res));
                chk({e.tag, " R7 cond"}, 32'(cond_out), 32'(e.cond));
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    function automatic logic [LANES*DW-1:0] ramp(input int base);
        logic [LANES*DW-1:0] r;
        for (int i = 0; i < LANES; i++) r[i*DW +: DW] = DW'(base + i * 3);
        return r;
    endfunction

    initial begin
        logic [LANES*DW-1:0] ones;
        for (int i = 0; i < LANES; i++) ones[i*DW +: DW] = '1;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 busy", 32'(busy), 0);
        chk("R1 done", 32'(done), 0);
        chk("R1 valid", 32'(result_valid), 0);
        chk("R1 result", 32'(result), 0);
        chk("R1 cond", 32'(cond_out), 0);
        rst_n = 1'b1;
        @(negedge clk);

        run(8, 8'hFF, ramp(1), "R4 full");              drain();
        run(0, 8'hFF, ramp(5), "R8 zero length");       drain();
        run(1, 8'h01, ramp(7), "R3 single");            drain();
        run(1, 8'h00, ramp(7), "R8 single off");        drain();
        run(8, 8'h80, ramp(9), "R6 last only");         drain();
        run(2, 8'h02, ramp(4), "R6 adopt");             drain();
        run(5, 8'hF6, ramp(2), "R2 mask above len");    drain();
        run(3, 8'h05, ramp(11), "R6 keep");             drain();
        run(7, 8'h5A, ramp(20), "R4 sparse");           drain();
        run(8, 8'hFF, ones, "R5 wrap");                 drain();

        // R9: a start during busy is ignored; R10: results hold afterwards.
        run(8, 8'hFF, ramp(100), "R9 first");
        @(negedge clk);
        chk("R9 busy during run", 32'(busy), 1);
        vlen = LW'(2); mask_in = 8'h03; elem_in = ramp(50); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        drain();
        begin
            exp_t e;
            e = model(8, 8'hFF, ramp(100), "R10");
            repeat (4) @(negedge clk);
            chk("R10 result held", 32'(result), 32'(e.res));
            chk("R10 cond held", 32'(cond_out), 32'(e.cond));
            chk("R10 valid held", 32'(result_valid), 32'(e.vld));
        end
        chk("R9 no pending", 32'(sb.size()), 0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule